// File: doc/BRIEF.md
# SRAM Functional Test Sequencer

This block exercises an external asynchronous byte-wide SRAM. It drives the address bus and the active-low chip-enable, output-enable and write-enable strobes. It also drives or releases an 8-bit data bus and selects a weak pull-up or pull-down on that bus. One `start` pulse launches three phases, always in the same order:

- a data-driver check at address 0;
- a pseudo-random fill of the selected range, followed by a verify of that range;
- optionally, a walking-one and walking-zero pass.

All accesses use a slow, fixed strobe timing. A programmable wait separates each write pass from its verify pass, so that cells which lose their contents while powered are caught.

The sequencer stops at the first mismatch. It then reports the phase, the address, the expected byte and the byte it observed. When no mismatch occurs, it ends with pass set. The tester sits between the SRAM socket and a host. The host sets the range, the advanced-test enable and the retention delay, pulses `start`, and waits for `done`.

Top module: `sram_test_seq`

## Requirements
- R1: After reset, `busy`, `done`, `pass` and `fail` are low, all three strobes are high and `dq_oe` is low.
- R2: A run performs the driver check (phase code 0), then the random pass (phase code 1), then the walking pass (phase code 2). It ends with `done` high and exactly one of `pass` or `fail` set.
- R3: The driver check writes 0x55 to address 0 and reads it back. A mismatch fails with phase 0, address 0, expected byte 0x55 and the observed byte.
- R4: The driver check then holds three strobe sets with WE high: CE low/OE high, CE high/OE low, and CE high/OE high. For each set it samples the bus first with `pull_up`=1, expecting 0xFF, then with `pull_up`=0, expecting 0x00. Any other value fails with phase 0, address 0 and the expected pull value.
- R5: The random data is the low byte of a 16-bit Galois LFSR. The LFSR shifts right, XORs 0xB400 when the bit shifted out is 1, starts from seed 0xACE1 and steps once per access. It is written to addresses 0..`addr_last` in order. It is then reseeded and verified in the same order.
- R6: The walking pass runs only when `adv_en` was high at start. For bit positions 0 to 7 in turn, it first writes the one-hot byte to every address and verifies it. It then writes the inverted byte to every address and verifies it.
- R7: Between each write pass and its verify pass, CE stays high for `ret_dly`+1 cycles. No such wait occurs in the driver check.
- R8: Each access lasts 3×`SETUP_CYC` cycles: address and data stable with CE low, then the strobe low, then the strobe high again. The read is sampled in the last strobe cycle. `dq_oe` is low whenever OE is low, and WE and OE are never low together.
- R9: On the first mismatch the sequencer stops and latches the phase, address, expected byte and observed byte. It then raises `done` with `fail` set. All results hold, with the strobes high, until the next start.
- R10: A `start` pulse during a run has no effect on that run.
- R11: No access uses an address above the `addr_last` captured at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a run when idle or finished |
| addr_last | input | AW | Highest address tested |
| adv_en | input | 1 | Include the walking-bit pass |
| ret_dly | input | DW | Retention wait in cycles (plus one) |
| sram_addr | output | AW | SRAM address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_out | output | 8 | Byte driven by the tester |
| sram_dq_oe | output | 1 | Tester drives the data bus |
| sram_dq_in | input | 8 | Sampled data bus |
| pull_up | output | 1 | 1 selects the weak pull-up, 0 the weak pull-down |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| pass | output | 1 | Finished with no mismatch |
| fail | output | 1 | Finished on a mismatch |
| fail_phase | output | 2 | Phase of the mismatch (0, 1 or 2) |
| fail_addr | output | AW | Address of the mismatch |
| fail_exp | output | 8 | Expected byte |
| fail_obs | output | 8 | Observed byte |

## Verification
On every cycle, the embedded assertions check the bus rules of R8:

- WE and OE are never low together;
- the tester releases the bus while OE is low;
- address and data stay still while a strobe is low.

They also check the end-of-run properties of R9 and R11: one result flag, an idle bus after a failure, and the address bound.

Only the bench scenarios can show the data behaviour: the phase order, the LFSR and walking patterns, the retention wait and the first-failure capture. To do so, a socket model injects read flips, stuck-at-zero bits, stray drivers and time-dependent bit decay. The bench then compares the reported phase, address and bytes, and the exact run length, with values computed from the requirements.

// File: rtl/sram_test_seq.sv
module sram_test_seq #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int SETUP_CYC = 2,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr_last,
  input  logic          adv_en,
  input  logic [DW-1:0] ret_dly,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  output logic [7:0]    sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [7:0]    sram_dq_in,
  output logic          pull_up,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [1:0]    fail_phase,
  output logic [AW-1:0] fail_addr,
  output logic [7:0]    fail_exp,
  output logic [7:0]    fail_obs
);
  localparam int TW = $clog2(SETUP_CYC + 1);
  localparam logic [TW-1:0] TLAST = TW'(SETUP_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_WAIT, S_FIN} st_t;
  typedef enum logic [2:0] {OP_DWR, OP_DRD, OP_FLT, OP_RWR, OP_RRD, OP_WWR, OP_WRD} op_t;

  st_t st;
  op_t op;
  logic [1:0]    step, combo;
  logic [TW-1:0] tcnt;
  logic [AW-1:0] addr, last_q;
  logic [DW-1:0] dcnt, ret_q;
  logic [15:0]   lfsr;
  logic [2:0]    wbit;
  logic          wcmp, adv_q, pull;

  function automatic logic [15:0] lfsr_nx(input logic [15:0] l);
    return {1'b0, l[15:1]} ^ (l[0] ? 16'hB400 : 16'h0000);
  endfunction

  logic [7:0] wpat, pat, flt_ce, flt_oe;
  logic is_wr, is_rd, at_last, sample;
  assign wpat    = 8'b1 << wbit;
  assign is_wr   = op inside {OP_DWR, OP_RWR, OP_WWR};
  assign is_rd   = op inside {OP_DRD, OP_RRD, OP_WRD, OP_FLT};
  assign at_last = (addr == last_q);
  assign sample  = (st == S_ACC) && (step == 2'd1) && (tcnt == TLAST) && is_rd;

  always_comb begin
    case (op)
      OP_DWR, OP_DRD: pat = 8'h55;
      OP_FLT:         pat = pull ? 8'hFF : 8'h00;
      OP_RWR, OP_RRD: pat = lfsr[7:0];
      default:        pat = wcmp ? ~wpat : wpat;
    endcase
  end

  // strobe sets held during float checks: {CE,OE} per combo index
  logic flt_ce_b, flt_oe_b;
  assign flt_ce = 8'b0000_0110;
  assign flt_oe = 8'b0000_0101;
  assign flt_ce_b = flt_ce[combo];
  assign flt_oe_b = flt_oe[combo];

  wire in_acc = (st == S_ACC);
  wire flt = in_acc && (op == OP_FLT);
  assign sram_addr   = addr;
  assign sram_dq_out = pat;
  assign sram_dq_oe  = in_acc && is_wr;
  assign sram_ce_n   = !in_acc || (flt && flt_ce_b);
  assign sram_we_n   = !(in_acc && is_wr && step == 2'd1);
  assign sram_oe_n   = flt ? flt_oe_b : !(in_acc && is_rd && step == 2'd1);
  assign pull_up     = pull;
  assign busy        = (st == S_ACC) || (st == S_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= OP_DWR; step <= '0; combo <= '0; tcnt <= '0;
      addr <= '0; last_q <= '0; dcnt <= '0; ret_q <= '0; lfsr <= SEED;
      wbit <= '0; wcmp <= 1'b0; adv_q <= 1'b0; pull <= 1'b1;
      done <= 1'b0; pass <= 1'b0; fail <= 1'b0;
      fail_phase <= '0; fail_addr <= '0; fail_exp <= '0; fail_obs <= '0;
    end else begin
      case (st)
        S_IDLE, S_FIN: if (start) begin
          st <= S_ACC; op <= OP_DWR; step <= '0; tcnt <= '0; combo <= '0;
          addr <= '0; last_q <= addr_last; adv_q <= adv_en; ret_q <= ret_dly;
          lfsr <= SEED; wbit <= '0; wcmp <= 1'b0; pull <= 1'b1;
          done <= 1'b0; pass <= 1'b0; fail <= 1'b0;
        end
        S_WAIT: if (dcnt == '0) st <= S_ACC; else dcnt <= dcnt - 1'b1;
        S_ACC: if (tcnt != TLAST) tcnt <= tcnt + 1'b1;
        else begin
          tcnt <= '0;
          if (sample && sram_dq_in != pat) begin
            st <= S_FIN; done <= 1'b1; fail <= 1'b1;
            fail_phase <= (op inside {OP_RWR, OP_RRD}) ? 2'd1 :
                          (op inside {OP_WWR, OP_WRD}) ? 2'd2 : 2'd0;
            fail_addr <= addr; fail_exp <= pat; fail_obs <= sram_dq_in;
          end else if (step != 2'd2) step <= step + 1'b1;
          else begin
            step <= '0;
            case (op)
              OP_DWR: op <= OP_DRD;
              OP_DRD: begin op <= OP_FLT; combo <= '0; pull <= 1'b1; end
              OP_FLT:
                if (pull) pull <= 1'b0;
                else if (combo != 2'd2) begin combo <= combo + 1'b1; pull <= 1'b1; end
                else begin op <= OP_RWR; pull <= 1'b1; end
              OP_RWR: begin
                lfsr <= lfsr_nx(lfsr);
                if (at_last) begin
                  addr <= '0; lfsr <= SEED; op <= OP_RRD; st <= S_WAIT; dcnt <= ret_q;
                end else addr <= addr + 1'b1;
              end
              OP_RRD: begin
                lfsr <= lfsr_nx(lfsr);
                if (!at_last) addr <= addr + 1'b1;
                else begin
                  addr <= '0;
                  if (adv_q) op <= OP_WWR;
                  else begin st <= S_FIN; done <= 1'b1; pass <= 1'b1; end
                end
              end
              OP_WWR:
                if (at_last) begin
                  addr <= '0; op <= OP_WRD; st <= S_WAIT; dcnt <= ret_q;
                end else addr <= addr + 1'b1;
              default:
                if (!at_last) addr <= addr + 1'b1;
                else begin
                  addr <= '0; op <= OP_WWR;
                  if (!wcmp) wcmp <= 1'b1;
                  else if (wbit == 3'd7) begin st <= S_FIN; done <= 1'b1; pass <= 1'b1; end
                  else begin wbit <= wbit + 1'b1; wcmp <= 1'b0; end
                end
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r8_we_oe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n));
  a_r8_bus_release: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_dq_oe);
  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && $past(!sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out)));
  a_r8_strobe_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sram_we_n) && !sram_ce_n) |-> $stable(sram_addr));
  a_r9_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ fail));
  a_r9_idle_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (sram_ce_n && sram_we_n && sram_oe_n && !busy));
  a_r11_range: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && (!sram_we_n || !sram_oe_n)) |-> (sram_addr <= last_q));
endmodule

// File: tb/sram_test_seq_tb.sv
module sram_test_seq_tb;
  localparam int CLK_P = 10;
  localparam int S = 2;
  localparam int LEAK = 300;

  logic clk = 0, rst_n = 0, start = 0, adv_en = 0;
  logic [7:0] addr_last = 0;
  logic [15:0] ret_dly = 0;
  logic [7:0] sram_addr, dq_out, dq_in, fail_exp, fail_obs, fail_addr;
  logic ce_n, oe_n, we_n, dq_oe, pull_up, busy, done, pass, fail;
  logic [1:0] fail_phase;

  always #(CLK_P/2) clk = ~clk;

  sram_test_seq #(.AW(8), .DW(16), .SETUP_CYC(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_last(addr_last), .adv_en(adv_en),
    .ret_dly(ret_dly), .sram_addr(sram_addr), .sram_ce_n(ce_n), .sram_oe_n(oe_n),
    .sram_we_n(we_n), .sram_dq_out(dq_out), .sram_dq_oe(dq_oe), .sram_dq_in(dq_in),
    .pull_up(pull_up), .busy(busy), .done(done), .pass(pass), .fail(fail),
    .fail_phase(fail_phase), .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_obs(fail_obs));

  // socket model with fault injection
  logic [7:0] mem [256];
  logic [7:0] f_addr = 0, f_flip = 0, f_stk0 = 0, f_leak = 0;
  int drvf = 0;
  int age = 0;
  logic [7:0] rd;
  logic drive;
  always_comb begin
    rd = mem[sram_addr];
    if (sram_addr == f_addr) begin
      rd = (rd ^ f_flip) & ~f_stk0;
      if (age > LEAK) rd = rd & ~f_leak;
    end
    drive = (!ce_n && !oe_n && we_n) || (drvf == 1 && !ce_n && oe_n && we_n) ||
            (drvf == 2 && ce_n && !oe_n);
    dq_in = dq_oe ? dq_out : drive ? rd : (pull_up ? 8'hFF : 8'h00);
  end
  always @(posedge clk) begin
    if (!ce_n && !we_n) mem[sram_addr] <= dq_in;
    if (!ce_n && !we_n && sram_addr == f_addr) age <= 0;
    else if (age < 100000) age <= age + 1;
  end

  int n_chk = 0, n_bad = 0;
  int busy_c, ceh_c, maxa;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] lbyte(input int k);
    logic [15:0] l = 16'hACE1;
    for (int i = 0; i < k; i++) l = {1'b0, l[15:1]} ^ (l[0] ? 16'hB400 : 16'h0000);
    return l[7:0];
  endfunction

  function automatic int run_len(input int l, input bit a, input int r);
    int acc = 8 + 2*(l+1) + (a ? 32*(l+1) : 0);
    return acc*3*S + (r+1)*(1 + (a ? 16 : 0));
  endfunction

  task automatic run(input int l, input bit a, input int r, input bit mid);
    int guard = 0;
    addr_last = 8'(l); adv_en = a; ret_dly = 16'(r);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    busy_c = 0; ceh_c = 0; maxa = 0;
    while (!done && guard < 40000) begin
      if (busy) busy_c++;
      if (busy && ce_n) ceh_c++;
      if (!ce_n && (!we_n || !oe_n) && int'(sram_addr) > maxa) maxa = int'(sram_addr);
      start = (mid && busy_c == 50);
      @(negedge clk);
      guard++;
    end
    start = 0;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
    end
  endtask

  task automatic clr_faults();
    f_flip = 0; f_stk0 = 0; f_leak = 0; drvf = 0; f_addr = 0;
  endtask

  task automatic chk_fail(input string tag, input int ph, input int ad, input int e, input int o);
    chk(fail && !pass, {tag, " fail flag"}, fail, 1);
    chk(fail_phase == 2'(ph), {tag, " phase"}, fail_phase, ph);
    chk(fail_addr == 8'(ad), {tag, " addr"}, fail_addr, ad);
    chk(fail_exp == 8'(e), {tag, " expected byte"}, fail_exp, e);
    chk(fail_obs == 8'(o), {tag, " observed byte"}, fail_obs, o);
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && !fail, "R1 flags", {busy, done, pass, fail}, 0);
    chk(ce_n && oe_n && we_n && !dq_oe, "R1 bus idle", {ce_n, oe_n, we_n, dq_oe}, 4'b1110);
    rst_n = 1;

    // R2 R7 R8 R11 directed basic pass
    run(15, 0, 3, 0);
    chk(done && pass && !fail, "R2 basic pass", {pass, fail}, 2'b10);
    chk(busy_c == run_len(15, 0, 3), "R8 run length", busy_c, run_len(15, 0, 3));
    chk(ceh_c == 12*S + 4, "R7 retention wait", ceh_c, 12*S + 4);
    chk(maxa == 15, "R11 range", maxa, 15);

    // constrained random clean runs
    for (int i = 0; i < 6; i++) begin
      int l = 1 + int'($urandom % 63);
      int r = int'($urandom % 16);
      run(l, 0, r, 0);
      chk(pass && !fail, "R5 random pass", pass, 1);
      chk(busy_c == run_len(l, 0, r), "R8 random run length", busy_c, run_len(l, 0, r));
      chk(ceh_c == 12*S + r + 1, "R7 random wait", ceh_c, 12*S + r + 1);
      chk(maxa == l, "R11 random range", maxa, l);
    end

    // R6 advanced clean
    run(7, 1, 2, 0);
    chk(pass && !fail, "R6 walking pass", pass, 1);
    chk(busy_c == run_len(7, 1, 2), "R6 walking length", busy_c, run_len(7, 1, 2));
    chk(ceh_c == 12*S + 3*17, "R7 walking waits", ceh_c, 12*S + 51);

    // R5 random read flips at random addresses
    for (int i = 0; i < 4; i++) begin
      int l = 8 + int'($urandom % 40);
      int fa = 1 + int'($urandom % l);
      logic [7:0] m = 8'b1 << ($urandom % 8);
      f_addr = 8'(fa); f_flip = m;
      run(l, 0, 1, 0);
      chk_fail("R5 flip", 1, fa, lbyte(fa), lbyte(fa) ^ m);
      clr_faults();
    end

    // R3 driver readback
    f_addr = 0; f_flip = 8'hFF;
    run(7, 0, 0, 0);
    chk_fail("R3 readback", 0, 0, 8'h55, 8'hAA);
    clr_faults();

    // R4 stray drivers
    drvf = 1; run(7, 0, 0, 0);
    chk_fail("R4 CE low OE high", 0, 0, 8'hFF, 8'h55);
    clr_faults();
    drvf = 2; run(7, 0, 0, 0);
    chk_fail("R4 CE high OE low", 0, 0, 8'hFF, 8'h55);
    clr_faults();

    // R9 results hold until next start
    f_addr = 5; f_flip = 8'h10;
    run(9, 0, 0, 0);
    clr_faults();
    repeat (20) @(negedge clk);
    chk(done && fail && fail_addr == 8'd5, "R9 held result", fail_addr, 5);
    chk(ce_n && we_n && oe_n && !busy, "R9 idle after stop", {ce_n, we_n, oe_n, busy}, 4'b1110);

    // R6 stuck-at-zero only seen by walking pass
    begin
      int fa = 3;
      int b = 0;
      while (lbyte(fa) == 8'hFF) fa++;
      while (lbyte(fa)[b]) b++;
      f_addr = 8'(fa); f_stk0 = 8'b1 << b;
      run(7, 0, 0, 0);
      chk(pass && !fail, "R6 walking skipped when disabled", pass, 1);
      run(7, 1, 0, 0);
      begin
        int e = -1;
        for (int k = 0; k < 16 && e < 0; k++) begin
          logic [7:0] p = 8'b1 << (k/2);
          if (k % 2 == 1) p = ~p;
          if (p[b]) e = int'(p);
        end
        chk_fail("R6 walking stuck bit", 2, fa, e, e & ~(1 << b));
      end
      clr_faults();
    end

    // R7 decay caught only with a long retention wait
    begin
      int fa = 4;
      logic [7:0] v;
      int b = 0;
      while (lbyte(fa) == 8'h00) fa++;
      v = lbyte(fa);
      while (!v[b]) b++;
      f_addr = 8'(fa); f_leak = 8'b1 << b;
      run(31, 0, 0, 0);
      chk(pass && !fail, "R7 short wait passes", pass, 1);
      run(31, 0, 400, 0);
      chk_fail("R7 decay", 1, fa, v, v & ~(8'b1 << b));
      clr_faults();
    end

    // R10 start during a run ignored
    run(20, 0, 5, 1);
    chk(pass && busy_c == run_len(20, 0, 5), "R10 mid-run start", busy_c, run_len(20, 0, 5));

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule